// File: doc/BRIEF.md
# Micro-op Cache Line Immediate Packer

This block takes a small, ordered group of decoded micro-ops and stores them in one cache line built from eight 32-bit slots. Each micro-op has a 16-bit payload and may carry an immediate of up to 64 bits. The block reduces every immediate to the fewest stored bits it can. A value that survives truncation to a signed 16-bit field stays inside the micro-op's own slot. A value that needs up to 32 signed bits places its upper half in the unused immediate field of a later micro-op that has no immediate of its own. Any other value spills into whole extension slots placed directly after its owner.

A pack request is taken in one clock and the line is registered. If the group needs more than eight slots, an overflow flag is raised and the line is left empty and invalid. A combinational unpack port reads the stored line and returns each micro-op in its original lane, with its payload and a 64-bit sign-extended immediate. The tags on each slot (kind, owning lane, lender link) let the unpack side rebuild any value without knowing which rule placed it.

Top module: `uop_line_packer`

## Requirements
- R1: After reset `lineValid` and `overflow` are 0, `slotsUsed` is 0, every slot kind is empty (0) and every `outValid` bit is 0.
- R2: A micro-op whose immediate has bits 63..15 all equal, or that carries no immediate, takes one slot of kind inline (1). The word holds the payload in bits 31..16 and immediate bits 15..0 (or zero when there is no immediate) in bits 15..0.
- R3: When an immediate does not fit in 16 bits but has bits 63..31 all equal, its low 16 bits stay in its own slot. Its bits 31..16 go into bits 15..0 of the head slot of the nearest later valid lane that has no immediate and is not already lending. That slot becomes kind lent (2). The borrower slot sets `slotLinked` and puts the lender's slot index in `slotLink`.
- R4: A wide immediate with no lender available takes extension slots (kind 3) right after its head slot. It takes one slot holding bits 31..16 if bits 63..31 are all equal. Otherwise it takes three slots holding bits 31..16, 47..32 and 63..48, in that order. Extension words have zero in bits 31..16.
- R5: Valid lanes are placed in lane order from slot 0 with no gaps. `slotsUsed` equals the number of occupied slots.
- R6: If the slots needed exceed 8, the pack sets `overflow`, clears `lineValid`, empties every slot and sets `slotsUsed` to 0. Otherwise `overflow` is 0 and `lineValid` is 1.
- R7: For every stored lane, the unpack port sets `outValid` and returns that lane's payload and its immediate sign-extended to 64 bits (zero when there is none). Lanes that are not stored have `outValid` at 0.
- R8: A cycle without `packValid` leaves the line, its tags, `slotsUsed`, `lineValid` and `overflow` unchanged, whatever the group inputs hold.
- R9: Every occupied slot's `slotOwner` holds the lane whose data it stores. A lent slot belongs to the lending lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| packValid | input | 1 | Pack the presented group this cycle |
| inValid | input | NU | Lane holds a micro-op |
| inHasImm | input | NU | Lane carries an immediate |
| inPayload | input | NU x PW | Opcode/operand payload per lane |
| inImm | input | NU x IMMW | Immediate per lane |
| lineValid | output | 1 | Stored line is valid |
| overflow | output | 1 | Last group did not fit |
| slotsUsed | output | UW | Occupied slot count |
| slotWord | output | NS x SLW | Stored slot words |
| slotKind | output | NS x 2 | Slot kind: 0 empty, 1 inline, 2 lent, 3 extension |
| slotOwner | output | NS x OW | Lane owning each slot |
| slotLinked | output | NS | Slot borrows a high half |
| slotLink | output | NS x SW | Index of the lending slot |
| outValid | output | NU | Unpacked lane present |
| outPayload | output | NU x PW | Unpacked payload |
| outImm | output | NU x IMMW | Unpacked, sign-extended immediate |

## Verification
Directed groups hit the signed 16-bit edges (32767, -32768 and one past each). These show whether the inline test is off by one bit. Further groups vary where the no-immediate lanes sit: one before the wide value, several after it, none at all. These tell nearest-later lending apart from a wrong search direction, and from re-lending a slot that is already in use. Three 64-bit values, and two that fill the line exactly, separate the overflow rule from its boundary. Random prefix groups drawn from boundary values then test the full round trip and the slot counts against a model of the placement rules. Idle cycles with scrambled inputs are placed between packs.

// File: rtl/uopk_pkg.sv
package uopk_pkg;
  typedef enum logic [1:0] {
    SK_EMPTY = 2'd0,
    SK_INL   = 2'd1,
    SK_LENT  = 2'd2,
    SK_EXT   = 2'd3
  } slotKind_e;

  // strobes from control to the line store
  typedef struct packed {
    logic load;
    logic clear;
  } lineStrobe_t;

  localparam int CHUNK = 16;
endpackage

// File: rtl/uopk_ctrl.sv
module uopk_ctrl
  import uopk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        packValid,
  input  logic        tooBig,
  output lineStrobe_t strobe,
  output logic        lineValid,
  output logic        overflow
);
  always_comb begin
    strobe.load  = packValid && !tooBig;
    strobe.clear = packValid && tooBig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= 1'b0;
      overflow  <= 1'b0;
    end else if (packValid) begin
      lineValid <= !tooBig;
      overflow  <= tooBig;
    end
  end
endmodule

// File: rtl/uopk_place.sv
module uopk_place
  import uopk_pkg::*;
#(
  parameter int NU   = 4,
  parameter int NS   = 8,
  parameter int PW   = 16,
  parameter int IMMW = 64,
  localparam int OW     = (NU > 1) ? $clog2(NU) : 1,
  localparam int SW     = (NS > 1) ? $clog2(NS) : 1,
  localparam int SLW    = PW + CHUNK,
  localparam int MAXEXT = IMMW / CHUNK - 1,
  localparam int EW     = $clog2(MAXEXT + 1),
  localparam int CW     = $clog2(NU * (MAXEXT + 1) + 1) + 1
) (
  input  logic [NU-1:0]            inValid,
  input  logic [NU-1:0]            inHasImm,
  input  logic [NU-1:0][PW-1:0]    inPayload,
  input  logic [NU-1:0][IMMW-1:0]  inImm,
  output logic [NS-1:0][SLW-1:0]   nxtWord,
  output logic [NS-1:0][1:0]       nxtKind,
  output logic [NS-1:0][OW-1:0]    nxtOwner,
  output logic [NS-1:0]            nxtLinked,
  output logic [NS-1:0][SW-1:0]    nxtLink,
  output logic [CW-1:0]            demand,
  output logic                     tooBig
);
  logic [NU-1:0]         fitsInline, fits32, lends, borrows;
  logic [NU-1:0][OW-1:0] lenderLane;
  logic [NU-1:0][EW-1:0] extCnt;
  logic [NU-1:0][CW-1:0] head;

  always_comb begin : classify
    for (int i = 0; i < NU; i++) begin
      fitsInline[i] = (inImm[i][IMMW-1:CHUNK-1] == '0) || (inImm[i][IMMW-1:CHUNK-1] == '1);
      fits32[i]     = (inImm[i][IMMW-1:2*CHUNK-1] == '0) || (inImm[i][IMMW-1:2*CHUNK-1] == '1);
    end
  end

  // lending search: nearest later lane with a free immediate field
  always_comb begin : pickLender
    logic found;
    found      = 1'b0;
    lends      = '0;
    borrows    = '0;
    lenderLane = '0;
    extCnt     = '0;
    for (int i = 0; i < NU; i++) begin
      if (inValid[i] && inHasImm[i] && !fitsInline[i]) begin
        found = 1'b0;
        if (fits32[i]) begin
          for (int j = 0; j < NU; j++) begin
            if (j > i && !found && inValid[j] && !inHasImm[j] && !lends[j]) begin
              found         = 1'b1;
              lends[j]      = 1'b1;
              lenderLane[i] = OW'(j);
            end
          end
        end
        borrows[i] = found;
        if (!found) extCnt[i] = fits32[i] ? EW'(1) : EW'(MAXEXT);
      end
    end
  end

  always_comb begin : allocate
    logic [CW-1:0] cur;
    cur = '0;
    for (int i = 0; i < NU; i++) begin
      head[i] = cur;
      if (inValid[i]) cur = cur + CW'(1) + CW'(extCnt[i]);
    end
    demand = cur;
  end

  assign tooBig = demand > CW'(NS);

  always_comb begin : fill
    for (int s = 0; s < NS; s++) begin
      nxtWord[s]   = '0;
      nxtKind[s]   = SK_EMPTY;
      nxtOwner[s]  = '0;
      nxtLinked[s] = 1'b0;
      nxtLink[s]   = '0;
    end
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NU; i++) begin
        if (inValid[i] && head[i] == CW'(s)) begin
          nxtWord[s]  = {inPayload[i], inHasImm[i] ? inImm[i][CHUNK-1:0] : {CHUNK{1'b0}}};
          nxtKind[s]  = SK_INL;
          nxtOwner[s] = OW'(i);
        end
        for (int e = 1; e <= MAXEXT; e++) begin
          if (inValid[i] && CW'(e) <= CW'(extCnt[i]) && head[i] + CW'(e) == CW'(s)) begin
            nxtWord[s]  = {{PW{1'b0}}, inImm[i][e*CHUNK +: CHUNK]};
            nxtKind[s]  = SK_EXT;
            nxtOwner[s] = OW'(i);
          end
        end
      end
    end
    // second pass: lent high halves and borrower links
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NU; i++) begin
        for (int j = 0; j < NU; j++) begin
          if (borrows[i] && lenderLane[i] == OW'(j)) begin
            if (head[j] == CW'(s)) begin
              nxtWord[s][CHUNK-1:0] = inImm[i][2*CHUNK-1:CHUNK];
              nxtKind[s]            = SK_LENT;
            end
            if (head[i] == CW'(s)) begin
              nxtLinked[s] = 1'b1;
              nxtLink[s]   = SW'(head[j]);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uopk_line.sv
module uopk_line
  import uopk_pkg::*;
#(
  parameter int NU   = 4,
  parameter int NS   = 8,
  parameter int PW   = 16,
  parameter int IMMW = 64,
  localparam int OW     = (NU > 1) ? $clog2(NU) : 1,
  localparam int SW     = (NS > 1) ? $clog2(NS) : 1,
  localparam int UW     = $clog2(NS + 1),
  localparam int SLW    = PW + CHUNK,
  localparam int MAXEXT = IMMW / CHUNK - 1,
  localparam int CW     = $clog2(NU * (MAXEXT + 1) + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lineStrobe_t              strobe,
  input  logic                     lineValid,
  input  logic [NS-1:0][SLW-1:0]   nxtWord,
  input  logic [NS-1:0][1:0]       nxtKind,
  input  logic [NS-1:0][OW-1:0]    nxtOwner,
  input  logic [NS-1:0]            nxtLinked,
  input  logic [NS-1:0][SW-1:0]    nxtLink,
  input  logic [CW-1:0]            demand,
  output logic [NS-1:0][SLW-1:0]   slotWord,
  output logic [NS-1:0][1:0]       slotKind,
  output logic [NS-1:0][OW-1:0]    slotOwner,
  output logic [NS-1:0]            slotLinked,
  output logic [NS-1:0][SW-1:0]    slotLink,
  output logic [UW-1:0]            slotsUsed,
  output logic [NU-1:0]            outValid,
  output logic [NU-1:0][PW-1:0]    outPayload,
  output logic [NU-1:0][IMMW-1:0]  outImm
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotWord   <= '0;
      slotKind   <= '0;
      slotOwner  <= '0;
      slotLinked <= '0;
      slotLink   <= '0;
      slotsUsed  <= '0;
    end else if (strobe.load) begin
      slotWord   <= nxtWord;
      slotKind   <= nxtKind;
      slotOwner  <= nxtOwner;
      slotLinked <= nxtLinked;
      slotLink   <= nxtLink;
      slotsUsed  <= UW'(demand);
    end else if (strobe.clear) begin
      slotWord   <= '0;
      slotKind   <= '0;
      slotOwner  <= '0;
      slotLinked <= '0;
      slotLink   <= '0;
      slotsUsed  <= '0;
    end
  end

  // unpack: gather chunks per lane, then sign-extend from the top gathered bit
  always_comb begin : rebuild
    logic [IMMW-1:0]        raw;
    logic signed [IMMW-1:0] wide;
    int                     n;
    int                     sh;
    raw        = '0;
    wide       = '0;
    n          = 0;
    sh         = 0;
    outValid   = '0;
    outPayload = '0;
    outImm     = '0;
    for (int lane = 0; lane < NU; lane++) begin
      for (int s = 0; s < NS; s++) begin
        if (lineValid && slotOwner[s] == OW'(lane) &&
            (slotKind[s] == SK_INL || slotKind[s] == SK_LENT)) begin
          outValid[lane]   = 1'b1;
          outPayload[lane] = slotWord[s][SLW-1:CHUNK];
          raw = '0;
          n   = 0;
          if (slotKind[s] == SK_INL) begin
            raw[CHUNK-1:0] = slotWord[s][CHUNK-1:0];
            if (slotLinked[s]) begin
              for (int t = 0; t < NS; t++)
                if (slotLink[s] == SW'(t)) raw[2*CHUNK-1:CHUNK] = slotWord[t][CHUNK-1:0];
              n = 1;
            end else begin
              for (int e = 1; e <= MAXEXT; e++) begin
                for (int t = 0; t < NS; t++) begin
                  if (t == s + e && n == e - 1 && slotKind[t] == SK_EXT &&
                      slotOwner[t] == OW'(lane)) begin
                    raw[e*CHUNK +: CHUNK] = slotWord[t][CHUNK-1:0];
                    n = e;
                  end
                end
              end
            end
          end
          sh   = IMMW - CHUNK * (n + 1);
          wide = $signed(raw << sh) >>> sh;
          outImm[lane] = wide;
        end
      end
    end
  end
endmodule

// File: rtl/uop_line_packer.sv
module uop_line_packer
  import uopk_pkg::*;
#(
  parameter int NU   = 4,
  parameter int NS   = 8,
  parameter int PW   = 16,
  parameter int IMMW = 64,
  localparam int OW     = (NU > 1) ? $clog2(NU) : 1,
  localparam int SW     = (NS > 1) ? $clog2(NS) : 1,
  localparam int UW     = $clog2(NS + 1),
  localparam int SLW    = PW + CHUNK,
  localparam int MAXEXT = IMMW / CHUNK - 1,
  localparam int CW     = $clog2(NU * (MAXEXT + 1) + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     packValid,
  input  logic [NU-1:0]            inValid,
  input  logic [NU-1:0]            inHasImm,
  input  logic [NU-1:0][PW-1:0]    inPayload,
  input  logic [NU-1:0][IMMW-1:0]  inImm,
  output logic                     lineValid,
  output logic                     overflow,
  output logic [UW-1:0]            slotsUsed,
  output logic [NS-1:0][SLW-1:0]   slotWord,
  output logic [NS-1:0][1:0]       slotKind,
  output logic [NS-1:0][OW-1:0]    slotOwner,
  output logic [NS-1:0]            slotLinked,
  output logic [NS-1:0][SW-1:0]    slotLink,
  output logic [NU-1:0]            outValid,
  output logic [NU-1:0][PW-1:0]    outPayload,
  output logic [NU-1:0][IMMW-1:0]  outImm
);
  lineStrobe_t            strobe;
  logic                   tooBig;
  logic [CW-1:0]          demand;
  logic [NS-1:0][SLW-1:0] nxtWord;
  logic [NS-1:0][1:0]     nxtKind;
  logic [NS-1:0][OW-1:0]  nxtOwner;
  logic [NS-1:0]          nxtLinked;
  logic [NS-1:0][SW-1:0]  nxtLink;

  uopk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .packValid(packValid), .tooBig(tooBig),
    .strobe(strobe), .lineValid(lineValid), .overflow(overflow)
  );

  uopk_place #(.NU(NU), .NS(NS), .PW(PW), .IMMW(IMMW)) u_place (
    .inValid(inValid), .inHasImm(inHasImm), .inPayload(inPayload), .inImm(inImm),
    .nxtWord(nxtWord), .nxtKind(nxtKind), .nxtOwner(nxtOwner),
    .nxtLinked(nxtLinked), .nxtLink(nxtLink), .demand(demand), .tooBig(tooBig)
  );

  uopk_line #(.NU(NU), .NS(NS), .PW(PW), .IMMW(IMMW)) u_line (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineValid(lineValid),
    .nxtWord(nxtWord), .nxtKind(nxtKind), .nxtOwner(nxtOwner),
    .nxtLinked(nxtLinked), .nxtLink(nxtLink), .demand(demand),
    .slotWord(slotWord), .slotKind(slotKind), .slotOwner(slotOwner),
    .slotLinked(slotLinked), .slotLink(slotLink), .slotsUsed(slotsUsed),
    .outValid(outValid), .outPayload(outPayload), .outImm(outImm)
  );
endmodule

// File: rtl/uopk_checker.sv
module uopk_checker
  import uopk_pkg::*;
#(
  parameter int NS  = 8,
  parameter int SLW = 32,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int UW = $clog2(NS + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   packValid,
  input logic                   lineValid,
  input logic                   overflow,
  input logic [UW-1:0]          slotsUsed,
  input logic [NS-1:0][SLW-1:0] slotWord,
  input logic [NS-1:0][1:0]     slotKind,
  input logic [NS-1:0]          slotLinked,
  input logic [NS-1:0][SW-1:0]  slotLink
);
  logic          gapFound, badLink, badExt;
  logic [UW-1:0] occCount;

  always_comb begin
    logic seenEmpty;
    logic ok;
    seenEmpty = 1'b0;
    ok        = 1'b0;
    gapFound  = 1'b0;
    occCount  = '0;
    badLink   = 1'b0;
    badExt    = (slotKind[0] == SK_EXT);
    for (int s = 0; s < NS; s++) begin
      if (slotKind[s] == SK_EMPTY) seenEmpty = 1'b1;
      else begin
        if (seenEmpty) gapFound = 1'b1;
        occCount = occCount + UW'(1);
      end
      if (s > 0 && slotKind[s] == SK_EXT && slotKind[s-1] == SK_EMPTY) badExt = 1'b1;
      if (slotLinked[s]) begin
        ok = 1'b0;
        for (int t = 0; t < NS; t++)
          if (slotLink[s] == SW'(t) && t > s && slotKind[t] == SK_LENT) ok = 1'b1;
        if (!ok) badLink = 1'b1;
      end
    end
  end

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    packValid |=> (lineValid != overflow));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (occCount == '0 && slotsUsed == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !packValid |=> ($stable(slotWord) && $stable(slotKind) && $stable(lineValid) && $stable(overflow)));

  assert_contig_R5: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> (!gapFound && occCount == slotsUsed));

  assert_link_target_R3: assert property (@(posedge clk) disable iff (!rstN) !badLink);

  assert_ext_follows_R4: assert property (@(posedge clk) disable iff (!rstN) !badExt);
endmodule

bind uop_line_packer uopk_checker #(.NS(NS), .SLW(SLW)) u_chk (
  .clk(clk), .rstN(rstN), .packValid(packValid), .lineValid(lineValid),
  .overflow(overflow), .slotsUsed(slotsUsed), .slotWord(slotWord),
  .slotKind(slotKind), .slotLinked(slotLinked), .slotLink(slotLink)
);

// File: tb/sim_uop_line_packer.sv
module sim_uop_line_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 4;
  localparam int NS = 8;
  localparam int PW = 16;
  localparam int IMMW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic packValid = 1'b0;
  logic [NU-1:0] inValid = '0;
  logic [NU-1:0] inHasImm = '0;
  logic [NU-1:0][PW-1:0] inPayload = '0;
  logic [NU-1:0][IMMW-1:0] inImm = '0;
  logic lineValid, overflow;
  logic [3:0] slotsUsed;
  logic [NS-1:0][31:0] slotWord;
  logic [NS-1:0][1:0] slotKind;
  logic [NS-1:0][1:0] slotOwner;
  logic [NS-1:0] slotLinked;
  logic [NS-1:0][2:0] slotLink;
  logic [NU-1:0] outValid;
  logic [NU-1:0][PW-1:0] outPayload;
  logic [NU-1:0][IMMW-1:0] outImm;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_line_packer u0 (
    .clk(clk), .rstN(rstN), .packValid(packValid), .inValid(inValid),
    .inHasImm(inHasImm), .inPayload(inPayload), .inImm(inImm),
    .lineValid(lineValid), .overflow(overflow), .slotsUsed(slotsUsed),
    .slotWord(slotWord), .slotKind(slotKind), .slotOwner(slotOwner),
    .slotLinked(slotLinked), .slotLink(slotLink), .outValid(outValid),
    .outPayload(outPayload), .outImm(outImm)
  );

  typedef struct packed {
    logic                    ovf;
    logic [3:0]              used;
    logic [NS-1:0][31:0]     word;
    logic [NS-1:0][1:0]      kind;
    logic [NS-1:0][1:0]      owner;
    logic [NS-1:0]           linked;
    logic [NS-1:0][2:0]      link;
    logic [NU-1:0]           lv;
    logic [NU-1:0][PW-1:0]   pay;
    logic [NU-1:0][IMMW-1:0] imm;
    logic                    hold;
  } expect_t;

  expect_t pend[$];
  expect_t lastExp;
  int total = 0;
  int bad = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit fit16(logic [63:0] v);
    return (v[63:15] == '0) || (v[63:15] == '1);
  endfunction

  function automatic bit fit32(logic [63:0] v);
    return (v[63:31] == '0) || (v[63:31] == '1);
  endfunction

  // reference placement built from the written rules
  function automatic expect_t model();
    expect_t e;
    int extc[NU];
    int head[NU];
    bit lent[NU];
    bit brw[NU];
    int lnd[NU];
    int cur;
    e = '0;
    for (int i = 0; i < NU; i++) begin
      extc[i] = 0; brw[i] = 0; lent[i] = 0; lnd[i] = 0;
    end
    for (int i = 0; i < NU; i++) begin
      if (inValid[i] && inHasImm[i] && !fit16(inImm[i])) begin
        if (fit32(inImm[i])) begin
          for (int j = i + 1; j < NU; j++)
            if (!brw[i] && inValid[j] && !inHasImm[j] && !lent[j]) begin
              brw[i] = 1; lent[j] = 1; lnd[i] = j;
            end
          if (!brw[i]) extc[i] = 1;
        end else extc[i] = 3;
      end
    end
    cur = 0;
    for (int i = 0; i < NU; i++) begin
      head[i] = cur;
      if (inValid[i]) cur += 1 + extc[i];
    end
    if (cur > NS) begin
      e.ovf = 1'b1;
      return e;
    end
    e.used = cur[3:0];
    for (int i = 0; i < NU; i++) begin
      if (inValid[i]) begin
        e.word[head[i]] = {inPayload[i], inHasImm[i] ? inImm[i][15:0] : 16'h0};
        e.kind[head[i]] = 2'd1;
        e.owner[head[i]] = i[1:0];
        for (int k = 1; k <= extc[i]; k++) begin
          e.word[head[i]+k] = {16'h0, inImm[i][16*k +: 16]};
          e.kind[head[i]+k] = 2'd3;
          e.owner[head[i]+k] = i[1:0];
        end
        e.lv[i] = 1'b1;
        e.pay[i] = inPayload[i];
        e.imm[i] = inHasImm[i] ? inImm[i] : 64'h0;
      end
    end
    for (int i = 0; i < NU; i++) begin
      if (brw[i]) begin
        e.word[head[lnd[i]]][15:0] = inImm[i][31:16];
        e.kind[head[lnd[i]]] = 2'd2;
        e.linked[head[i]] = 1'b1;
        e.link[head[i]] = head[lnd[i]][2:0];
      end
    end
    return e;
  endfunction

  task automatic compare(expect_t e);
    string rk;
    chk(overflow == e.ovf, e.hold ? "R8" : "R6", "overflow", 64'(overflow), 64'(e.ovf));
    chk(lineValid == !e.ovf, e.hold ? "R8" : "R6", "lineValid", 64'(lineValid), 64'(!e.ovf));
    chk(slotsUsed == e.used, e.hold ? "R8" : "R5", "slotsUsed", 64'(slotsUsed), 64'(e.used));
    for (int s = 0; s < NS; s++) begin
      if (e.hold) rk = "R8";
      else if (e.kind[s] == 2'd1) rk = "R2";
      else if (e.kind[s] == 2'd2) rk = "R3";
      else if (e.kind[s] == 2'd3) rk = "R4";
      else rk = "R5";
      chk(slotKind[s] == e.kind[s], rk, $sformatf("kind[%0d]", s), 64'(slotKind[s]), 64'(e.kind[s]));
      chk(slotWord[s] == e.word[s], rk, $sformatf("word[%0d]", s), 64'(slotWord[s]), 64'(e.word[s]));
      if (e.kind[s] != 2'd0)
        chk(slotOwner[s] == e.owner[s], e.hold ? "R8" : "R9", $sformatf("owner[%0d]", s),
            64'(slotOwner[s]), 64'(e.owner[s]));
      chk(slotLinked[s] == e.linked[s] && (!e.linked[s] || slotLink[s] == e.link[s]), "R3",
          $sformatf("link[%0d]", s), {60'h0, slotLinked[s], slotLink[s]}, {60'h0, e.linked[s], e.link[s]});
    end
    for (int l = 0; l < NU; l++) begin
      chk(outValid[l] == e.lv[l], "R7", $sformatf("outValid[%0d]", l), 64'(outValid[l]), 64'(e.lv[l]));
      if (e.lv[l]) begin
        chk(outPayload[l] == e.pay[l], "R7", $sformatf("outPayload[%0d]", l), 64'(outPayload[l]), 64'(e.pay[l]));
        chk(outImm[l] == e.imm[l], "R7", $sformatf("outImm[%0d]", l), outImm[l], e.imm[l]);
      end
    end
  endtask

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (pend.size() > 0) compare(pend.pop_front());
  end

  task automatic pack(logic [NU-1:0] v, logic [NU-1:0] h, logic [NU-1:0][IMMW-1:0] im);
    @(negedge clk);
    inValid = v;
    inHasImm = h;
    inImm = im;
    for (int i = 0; i < NU; i++) inPayload[i] = PW'($urandom);
    packValid = 1'b1;
    @(posedge clk);
    #1;
    lastExp = model();
    pend.push_back(lastExp);
  endtask

  task automatic idle();
    expect_t e;
    @(negedge clk);
    packValid = 1'b0;
    inValid = NU'($urandom);
    inHasImm = NU'($urandom);
    for (int i = 0; i < NU; i++) begin
      inImm[i] = {$urandom, $urandom};
      inPayload[i] = PW'($urandom);
    end
    @(posedge clk);
    #1;
    e = lastExp;
    e.hold = 1'b1;
    pend.push_back(e);
  endtask

  function automatic logic [63:0] pickImm();
    case ($urandom % 12)
      0: return 64'd0;
      1: return 64'd32767;
      2: return -64'sd32768;
      3: return 64'd32768;
      4: return -64'sd32769;
      5: return 64'h0000_0000_7FFF_FFFF;
      6: return 64'hFFFF_FFFF_8000_0000;
      7: return 64'h0000_0000_8000_0000;
      8: return 64'hFFFF_FFFF_7FFF_FFFF;
      9: return 64'(signed'($urandom));
      10: return -64'sd1;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [NU-1:0][IMMW-1:0] im;
    logic [NU-1:0] v;
    logic [NU-1:0] h;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lineValid == 1'b0, "R1", "lineValid", 64'(lineValid), 64'h0);
    chk(overflow == 1'b0, "R1", "overflow", 64'(overflow), 64'h0);
    chk(slotsUsed == 4'd0, "R1", "slotsUsed", 64'(slotsUsed), 64'h0);
    chk(slotKind == '0, "R1", "slotKind", 64'(slotKind), 64'h0);
    chk(outValid == '0, "R1", "outValid", 64'(outValid), 64'h0);

    pack(4'b1111, 4'b0000, '0);                                         // R2 no immediates
    pack(4'b1111, 4'b1111, {64'd0, -64'sd1, 64'd32767, -64'sd32768});   // R2 inline edges
    pack(4'b1111, 4'b0001, {64'd0, 64'd0, 64'd0, 64'd32768});           // R3 lend from lane 1
    pack(4'b1111, 4'b0011, {64'd0, 64'd0, 64'h7FFF_FFFF, -64'sd32769}); // R3 two lenders
    pack(4'b1111, 4'b0011, {64'd0, 64'd0, 64'd5, 64'h0001_2345});       // R3 lender skips imm lane
    pack(4'b1111, 4'b0111, {64'd0, 64'hFFFF_FFFF_8000_0000, 64'h1_0000, 64'h1234_0000}); // R4 one ext
    pack(4'b1111, 4'b1110, {64'd32768, 64'd65536, 64'h7FFF_0000, 64'd0}); // R4 no later lender
    pack(4'b1111, 4'b1000, {64'hFFFF_FFFF_7FFF_FFFF, 64'd0, 64'd0, 64'd0}); // R4 three ext
    idle();                                                             // R8
    pack(4'b0011, 4'b0011, {64'd0, 64'd0, 64'h0000_0100_0000_0000, 64'h0000_0000_8000_0000}); // R5 exact 8
    pack(4'b0111, 4'b0111, {64'd0, 64'h1_0000_0000, 64'h8000_0000, 64'hF000_0000_0000_0000}); // R6 overflow
    idle();                                                             // R8 after overflow
    pack(4'b1111, 4'b0000, '0);                                         // recovery

    for (int it = 0; it < 400; it++) begin
      n = 1 + ($urandom % NU);
      v = '0;
      h = '0;
      im = '0;
      for (int i = 0; i < NU; i++) begin
        if (i < n) begin
          v[i] = 1'b1;
          h[i] = $urandom % 2;
          if (h[i]) im[i] = pickImm();
        end
      end
      pack(v, h, im);
      if (it % 7 == 3) idle();
    end
    @(negedge clk);
    packValid = 1'b0;
    while (pend.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule